// File: doc/BRIEF.md
# Infrared Frame Status Register

This block is the 8-bit status and command register of an infrared serial controller that works in framed (medium and fast speed) modes and in a remote-control mode. A CPU reaches it over a plain register bus: a select, a read strobe, a write strobe and an 8-bit write data bus. Read data is combinational while select and read strobe are both high, and is zero at all other times.

The register holds sticky event flags raised by the transmit and receive datapaths, each cleared by one of two rules: a read of the register, or a write with a 1 in the flag's own position. It also shows live receiver status, and it holds a software frame-end command. A small transmit-frame state machine decides whether the transmitter running dry is an underrun. It has three states. FR_OPEN means a frame is in progress and not yet closed. FR_CLOSED_SW means software has written the frame-end command. FR_CLOSED_TC means the DMA terminal count has arrived. The transition OPEN_TO_SW is taken on a write of bit 3 = 1 when not in DMA mode. OPEN_TO_TC is taken on a terminal count in DMA mode. CLOSED_TO_OPEN is taken from either closed state once the transmitter reports that the frame end has gone out.

Top module: `irsr_frame_status`

## Requirements
- R1: After reset every sticky flag is 0, the frame-end command is 0 and the state machine is in FR_OPEN. A read with all live inputs low returns 8'h00.
- R2: `rdata` equals the register contents only while `sel` and `rd_en` are both high, and is 8'h00 otherwise. Bit 2 always reads 0. A read returns the flag values from before that read's own clear takes effect.
- R3: Bit 7 (flow control) is set by `ev_flow_ctl` at a clock edge and is cleared by a read.
- R4: When not in DMA mode, bit 6 (underrun) is set when `ev_tx_empty` occurs while no frame-end command is pending (state FR_OPEN). No underrun is raised while the command is pending.
- R5: In DMA mode, `ev_dma_tc` moves the state to FR_CLOSED_TC, after which `ev_tx_empty` raises no underrun. `ev_tx_empty` before the terminal count does raise an underrun.
- R6: Bit 6 clears only on a write with `wdata[6]` = 1. Reads and writes with `wdata[6]` = 0 leave it unchanged.
- R7: Bit 5 is live: `rx_busy` in framed mode (`remote_mode` = 0), `rx_in_proc` in remote mode.
- R8: Bit 4 is set by `ev_frame_lost` in framed mode and by `ev_pulse_seen` in remote mode. In both modes a read clears it.
- R9: Bit 3 reads 1 while the frame-end command is pending (state FR_CLOSED_SW) and drives `tx_fend_req`. A write with `wdata[3]` = 1 sets it only when `dma_mode` = 0 and the state is FR_OPEN. It clears on `ev_tx_fend_sent`. Writing 0 to it has no effect.
- R10: Bit 1 is live `fend_held` in framed mode and reads 0 in remote mode.
- R11: Bit 0 is set by `ev_rx_timeout` or `ev_fs_timeout` and is cleared by a read.
- R12: When a set event and a clear for the same flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register select |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |
| remote_mode | input | 1 | 1 = remote-control mode, 0 = framed mode |
| dma_mode | input | 1 | 1 = transmit fed by DMA, 0 = programmed I/O |
| ev_flow_ctl | input | 1 | Flow-control event pulse |
| ev_tx_empty | input | 1 | Transmitter ran empty |
| ev_dma_tc | input | 1 | DMA terminal count |
| ev_tx_fend_sent | input | 1 | Transmitter has sent the frame end |
| ev_frame_lost | input | 1 | Frame end lost (framed mode) |
| ev_pulse_seen | input | 1 | Remote pulse detected (remote mode) |
| ev_rx_timeout | input | 1 | Receive FIFO timeout |
| ev_fs_timeout | input | 1 | Frame-status FIFO timeout |
| rx_busy | input | 1 | Receiver busy (framed mode) |
| rx_in_proc | input | 1 | Receiver in process (remote mode) |
| fend_held | input | 1 | At least one frame end held in the receive FIFO |
| tx_fend_req | output | 1 | Pending software frame-end command to the transmitter |

## Verification
On every cycle the assertions check these properties: a flow-control event always leaves bit 7 set, a read with no new set always clears it, the underrun flag survives any cycle without a write of 1 to it, no underrun appears while a software frame end is pending, the command drops after the frame end is sent, and read data is zero outside a read. The bench scenarios show the mode-dependent meaning of bits 1, 4 and 5, the DMA path through FR_CLOSED_TC, the refusal of the command in DMA mode, and the values returned by reads that clear. These checks depend on sequences of events and reads that no single-cycle property captures.

// File: rtl/irsr_pkg.sv
package irsr_pkg;
    localparam int REG_W     = 8;
    localparam int BIT_FLOW  = 7;
    localparam int BIT_UNDRN = 6;
    localparam int BIT_RXACT = 5;
    localparam int BIT_LOST  = 4;
    localparam int BIT_FEND  = 3;
    localparam int BIT_HELD  = 1;
    localparam int BIT_TMO   = 0;
    localparam int N_STICKY  = 4;

    typedef enum logic [1:0] {
        FR_OPEN      = 2'd0,
        FR_CLOSED_SW = 2'd1,
        FR_CLOSED_TC = 2'd2
    } fr_state_e;
endpackage

// File: rtl/irsr_sticky_bank.sv
module irsr_sticky_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_o[g] <= 1'b0;
            end else begin
                // set has priority over clear
                q_o[g] <= set_i[g] | (q_o[g] & ~clr_i[g]);
            end
        end
    end
endmodule

// File: rtl/irsr_tx_frame_fsm.sv
module irsr_tx_frame_fsm
    import irsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dma_mode,
    input  logic fend_wr,
    input  logic dma_tc,
    input  logic fend_sent,
    input  logic tx_empty,
    output logic fend_cmd,
    output logic underrun_set
);
    fr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_OPEN: begin
                if (!dma_mode && fend_wr) begin
                    state_d = FR_CLOSED_SW;          // OPEN_TO_SW
                end else if (dma_mode && dma_tc) begin
                    state_d = FR_CLOSED_TC;          // OPEN_TO_TC
                end
            end
            FR_CLOSED_SW, FR_CLOSED_TC: begin
                if (fend_sent) begin
                    state_d = FR_OPEN;               // CLOSED_TO_OPEN
                end
            end
            default: state_d = FR_OPEN;
        endcase
    end

    always_comb begin
        fend_cmd     = 1'b0;
        underrun_set = 1'b0;
        unique case (state_q)
            FR_OPEN:      underrun_set = tx_empty;
            FR_CLOSED_SW: fend_cmd     = 1'b1;
            FR_CLOSED_TC: fend_cmd     = 1'b0;
            default:      fend_cmd     = 1'b0;
        endcase
    end
endmodule

// File: rtl/irsr_frame_status.sv
module irsr_frame_status
    import irsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             remote_mode,
    input  logic             dma_mode,
    input  logic             ev_flow_ctl,
    input  logic             ev_tx_empty,
    input  logic             ev_dma_tc,
    input  logic             ev_tx_fend_sent,
    input  logic             ev_frame_lost,
    input  logic             ev_pulse_seen,
    input  logic             ev_rx_timeout,
    input  logic             ev_fs_timeout,
    input  logic             rx_busy,
    input  logic             rx_in_proc,
    input  logic             fend_held,
    output logic             tx_fend_req
);
    // sticky slot order inside the bank
    localparam int S_TMO = 0, S_LOST = 1, S_UNDRN = 2, S_FLOW = 3;

    logic                rd_hit, wr_hit;
    logic                underrun_set;
    logic [N_STICKY-1:0] st_set, st_clr, st_q;
    logic [REG_W-1:0]    status_w;
    logic                unused_wdata;

    assign rd_hit       = sel & rd_en;
    assign wr_hit       = sel & wr_en;
    assign unused_wdata = ^{wdata[7], wdata[5:4], wdata[2:0]};

    irsr_tx_frame_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .dma_mode     (dma_mode),
        .fend_wr      (wr_hit & wdata[BIT_FEND]),
        .dma_tc       (ev_dma_tc),
        .fend_sent    (ev_tx_fend_sent),
        .tx_empty     (ev_tx_empty),
        .fend_cmd     (tx_fend_req),
        .underrun_set (underrun_set)
    );

    always_comb begin
        st_set[S_FLOW]  = ev_flow_ctl;
        st_set[S_UNDRN] = underrun_set;
        st_set[S_LOST]  = remote_mode ? ev_pulse_seen : ev_frame_lost;
        st_set[S_TMO]   = ev_rx_timeout | ev_fs_timeout;
        st_clr[S_FLOW]  = rd_hit;
        st_clr[S_UNDRN] = wr_hit & wdata[BIT_UNDRN];
        st_clr[S_LOST]  = rd_hit;
        st_clr[S_TMO]   = rd_hit;
    end

    irsr_sticky_bank #(.N(N_STICKY)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (st_set),
        .clr_i (st_clr),
        .q_o   (st_q)
    );

    always_comb begin
        status_w            = '0;
        status_w[BIT_FLOW]  = st_q[S_FLOW];
        status_w[BIT_UNDRN] = st_q[S_UNDRN];
        status_w[BIT_RXACT] = remote_mode ? rx_in_proc : rx_busy;
        status_w[BIT_LOST]  = st_q[S_LOST];
        status_w[BIT_FEND]  = tx_fend_req;
        status_w[BIT_HELD]  = fend_held & ~remote_mode;
        status_w[BIT_TMO]   = st_q[S_TMO];
    end

    assign rdata = rd_hit ? status_w : '0;
endmodule

// File: rtl/irsr_frame_status_chk.sv
module irsr_frame_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       rd_en,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] status,
    input logic       ev_flow_ctl,
    input logic       ev_tx_fend_sent,
    input logic       tx_fend_req
);
    logic rd_hit, w1c_und;
    assign rd_hit  = sel & rd_en;
    assign w1c_und = sel & wr_en & wdata[6];

    AST_FLOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_flow_ctl |=> status[7]);                                   // R12
    AST_FLOW_COR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !ev_flow_ctl) |=> !status[7]);                     // R3
    AST_UNDRN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && !w1c_und) |=> status[6]);                       // R6
    AST_NO_UNDRN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[6] && tx_fend_req) |=> !status[6]);                  // R4
    AST_FEND_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fend_req && ev_tx_fend_sent) |=> !tx_fend_req);           // R9
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (rdata == 8'h00));                                // R2
endmodule

bind irsr_frame_status irsr_frame_status_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sel             (sel),
    .rd_en           (rd_en),
    .wr_en           (wr_en),
    .wdata           (wdata),
    .rdata           (rdata),
    .status          (status_w),
    .ev_flow_ctl     (ev_flow_ctl),
    .ev_tx_fend_sent (ev_tx_fend_sent),
    .tx_fend_req     (tx_fend_req)
);

// File: tb/irsr_frame_status_tb.sv
module irsr_frame_status_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 4000;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       sel = 0, rd_en = 0, wr_en = 0;
    logic [7:0] wdata = 0, rdata;
    logic       remote_mode = 0, dma_mode = 0;
    logic       ev_flow_ctl = 0, ev_tx_empty = 0, ev_dma_tc = 0, ev_tx_fend_sent = 0;
    logic       ev_frame_lost = 0, ev_pulse_seen = 0, ev_rx_timeout = 0, ev_fs_timeout = 0;
    logic       rx_busy = 0, rx_in_proc = 0, fend_held = 0, tx_fend_req;

    int n_chk = 0, n_fail = 0;
    logic [7:0] last_rd;

    // reference state
    logic m_flow, m_und, m_lost, m_tmo;
    int   m_st; // 0 open, 1 closed by software, 2 closed by terminal count

    always #(CLK_PERIOD/2) clk = ~clk;

    irsr_frame_status dut_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .remote_mode(remote_mode), .dma_mode(dma_mode),
        .ev_flow_ctl(ev_flow_ctl), .ev_tx_empty(ev_tx_empty), .ev_dma_tc(ev_dma_tc),
        .ev_tx_fend_sent(ev_tx_fend_sent), .ev_frame_lost(ev_frame_lost),
        .ev_pulse_seen(ev_pulse_seen), .ev_rx_timeout(ev_rx_timeout),
        .ev_fs_timeout(ev_fs_timeout), .rx_busy(rx_busy), .rx_in_proc(rx_in_proc),
        .fend_held(fend_held), .tx_fend_req(tx_fend_req)
    );

    function automatic logic [7:0] exp_read();
        logic [7:0] e;
        e    = 8'h00;
        e[7] = m_flow;
        e[6] = m_und;
        e[5] = remote_mode ? rx_in_proc : rx_busy;
        e[4] = m_lost;
        e[3] = (m_st == 1);
        e[1] = fend_held & ~remote_mode;
        e[0] = m_tmo;
        return e;
    endfunction

    function automatic string bit_req(int b);
        case (b)
            7: return "R3";  6: return "R6";  5: return "R7";  4: return "R8";
            3: return "R9";  2: return "R2";  1: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_bit(string req, int b, logic exp);
        chk(req, {7'd0, last_rd[b]}, {7'd0, exp});
    endtask

    task automatic model_step();
        logic rd, wr;
        rd = sel & rd_en;
        wr = sel & wr_en;
        m_flow = ev_flow_ctl | (m_flow & ~rd);
        m_und  = (ev_tx_empty && m_st == 0) | (m_und & ~(wr & wdata[6]));
        m_lost = (remote_mode ? ev_pulse_seen : ev_frame_lost) | (m_lost & ~rd);
        m_tmo  = ev_rx_timeout | ev_fs_timeout | (m_tmo & ~rd);
        if (m_st == 0) begin
            if (!dma_mode && wr && wdata[3]) m_st = 1;
            else if (dma_mode && ev_dma_tc)  m_st = 2;
        end else if (ev_tx_fend_sent) begin
            m_st = 0;
        end
    endtask

    // one bus cycle: inputs already set after a falling edge
    task automatic tick();
        #(CLK_PERIOD/4);
        last_rd = rdata;
        if (sel && rd_en) begin
            logic [7:0] e;
            e = exp_read();
            for (int b = 0; b < 8; b++) chk(bit_req(b), {7'd0, rdata[b]}, {7'd0, e[b]});
        end else begin
            chk("R2", rdata, 8'h00);
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        sel = 0; rd_en = 0; wr_en = 0; wdata = 0;
        ev_flow_ctl = 0; ev_tx_empty = 0; ev_dma_tc = 0; ev_tx_fend_sent = 0;
        ev_frame_lost = 0; ev_pulse_seen = 0; ev_rx_timeout = 0; ev_fs_timeout = 0;
    endtask

    task automatic do_read();
        idle(); sel = 1; rd_en = 1; tick();
    endtask

    task automatic do_write(logic [7:0] d);
        idle(); sel = 1; wr_en = 1; wdata = d; tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog R1 actual=hang expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        m_flow = 0; m_und = 0; m_lost = 0; m_tmo = 0; m_st = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        do_read(); chk("R1", last_rd, 8'h00);
        idle(); tick(); chk("R2", last_rd, 8'h00);

        // R4: programmed I/O underrun, then R6 read does not clear, W1C does
        idle(); ev_tx_empty = 1; tick();
        do_read(); chk_bit("R4", 6, 1'b1);
        do_read(); chk_bit("R6", 6, 1'b1);
        do_write(8'hBF); do_read(); chk_bit("R6", 6, 1'b1);
        do_write(8'h40); do_read(); chk_bit("R6", 6, 1'b0);

        // R9: command closes the frame, no underrun while pending
        do_write(8'h08); do_read(); chk_bit("R9", 3, 1'b1);
        chk("R9", {7'd0, tx_fend_req}, 8'h01);
        idle(); ev_tx_empty = 1; tick();
        do_read(); chk_bit("R4", 6, 1'b0);
        idle(); ev_tx_fend_sent = 1; tick();
        do_read(); chk_bit("R9", 3, 1'b0);

        // R5 / R9: DMA mode ignores the command bit, terminal count closes
        dma_mode = 1;
        do_write(8'h08); do_read(); chk_bit("R9", 3, 1'b0);
        idle(); ev_tx_empty = 1; tick();
        do_read(); chk_bit("R5", 6, 1'b1);
        do_write(8'h40);
        idle(); ev_dma_tc = 1; tick();
        idle(); ev_tx_empty = 1; tick();
        do_read(); chk_bit("R5", 6, 1'b0);
        idle(); ev_tx_fend_sent = 1; tick();
        dma_mode = 0;

        // R12: set and read clear in the same cycle
        idle(); sel = 1; rd_en = 1; ev_flow_ctl = 1; ev_rx_timeout = 1; tick();
        do_read(); chk_bit("R12", 7, 1'b1); chk_bit("R12", 0, 1'b1);
        do_read(); chk_bit("R3", 7, 1'b0); chk_bit("R11", 0, 1'b0);

        // R8 / R10 / R7: remote mode meaning
        remote_mode = 1; fend_held = 1; rx_in_proc = 1; rx_busy = 0;
        idle(); ev_frame_lost = 1; tick();
        do_read(); chk_bit("R8", 4, 1'b0); chk_bit("R10", 1, 1'b0); chk_bit("R7", 5, 1'b1);
        idle(); ev_pulse_seen = 1; tick();
        do_read(); chk_bit("R8", 4, 1'b1);
        remote_mode = 0;
        do_read(); chk_bit("R10", 1, 1'b1); chk_bit("R7", 5, 1'b0);
        fend_held = 0; rx_in_proc = 0;

        // random mix, R2..R12 compared field by field on each read
        for (int i = 0; i < N_RAND; i++) begin
            idle();
            if ($urandom % 40 == 0) remote_mode = ~remote_mode;
            if ($urandom % 50 == 0) dma_mode    = ~dma_mode;
            sel             = ($urandom % 4) != 0;
            rd_en           = ($urandom % 2) == 0;
            wr_en           = !rd_en && (($urandom % 3) == 0);
            wdata           = 8'($urandom);
            ev_flow_ctl     = ($urandom % 8) == 0;
            ev_tx_empty     = ($urandom % 6) == 0;
            ev_dma_tc       = ($urandom % 8) == 0;
            ev_tx_fend_sent = ($urandom % 6) == 0;
            ev_frame_lost   = ($urandom % 9) == 0;
            ev_pulse_seen   = ($urandom % 9) == 0;
            ev_rx_timeout   = ($urandom % 12) == 0;
            ev_fs_timeout   = ($urandom % 12) == 0;
            rx_busy         = 1'($urandom);
            rx_in_proc      = 1'($urandom);
            fend_held       = 1'($urandom);
            tick();
            chk("R9", {7'd0, tx_fend_req}, {7'd0, (m_st == 1)});
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule